// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block runs one complete NAND flash operation from a pair of control words written over a simple register port. The first word gives the opening opcode, the direction of the data phase and how many address bytes follow. The second word can add a closing opcode, so that two-step operations such as erase, page program and large-page read go out as one hardware transaction instead of two separate software steps.

The sequencer drives the command-latch, address-latch, write-strobe and read-strobe lines of an 8-bit NAND bus. It takes address bytes from two address registers and moves a programmed number of bytes between the flash and a local page buffer, which sits outside the block behind a byte-wide port. After the last write strobe it waits a guard interval, then waits for the device ready line, with a timeout. Completion, end of transfer, timeout and a rejected start each set a write-one-to-clear status bit. A mask register gates these bits onto one interrupt line.

Top module: `nand_op_seq`

## Requirements
- R1: After reset the command-latch and address-latch lines are low, both strobes are high, the bus is not driven, the status word is zero and the interrupt line is low.
- R2: A write to register 0 with bit 31 set starts an operation. Its first bus cycle latches bits 7:0 of that word with the command-latch line high. A write to register 0 with bit 31 clear starts nothing.
- R3: When bit 30 of the start word is set, the sequencer sends bits 29:27 plus one address bytes with the address-latch line high. The bytes are taken low byte first from the 16-bit register 2 and then from the 24-bit register 3. When bit 30 is clear, no address byte is sent.
- R4: When bit 25 of the start word is set, the sequencer sends N+1 data bytes after the address, where N is register 4. The bytes are read from buffer addresses 0 to N in order, with both latch lines low.
- R5: When bit 8 of register 1 is set, bits 7:0 of register 1 are latched with the command-latch line high as a closing opcode. For a read (bit 26 set) it goes right after the address. Otherwise it goes after the write data.
- R6: When bit 26 of the start word is set, once the device is ready the sequencer reads N+1 bytes with the read strobe and stores byte k at buffer address k.
- R7: At least TWB_CYC clock cycles pass between the last write strobe rising and either the ready line being acted on or the first read strobe falling.
- R8: Register 5 reads out on the status port. Bit 31 marks operation done and bit 28 marks data phase done. A read sets both at its last byte. A write sets bit 28 at its last byte and bit 31 once the device is ready. Writing ones to register 5 clears those bits, but a bit being set in the same cycle stays set. The interrupt line is the OR of the status word ANDed with register 6.
- R9: A write to register 0 while an operation runs is ignored, and it sets sticky status bit 0.
- R10: If the ready line stays low for TIMEOUT_CYC cycles, the operation ends with the bus idle. Status bit 1 is set and bit 31 is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register index |
| regWdata | input | 32 | Register write data |
| irq | output | 1 | Masked interrupt |
| irqStatus | output | 32 | Status word |
| bufAddr | output | LEN_W | Page buffer byte address |
| bufWe | output | 1 | Page buffer write enable |
| bufWdata | output | 8 | Byte read from flash, to buffer |
| bufRdata | input | 8 | Byte from buffer, to flash |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandDout | output | 8 | Bus data out |
| nandDoe | output | 1 | Bus output enable |
| nandDin | input | 8 | Bus data in |
| nandRb | input | 1 | Ready (high) / busy (low) |

## Verification
Software clearing the done bit and the sequencer setting it can happen in the same cycle. The bench counts read strobe rising edges during an ID read. Once the last one is seen, it places a write-one-to-clear of bits 31 and 28 on the very next clock edge, which is the edge where the final byte completes. It then expects both bits still set, and expects a later clear with no competing set to empty them.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam logic [2:0] REG_CTL1    = 3'd0;
  localparam logic [2:0] REG_CTL2    = 3'd1;
  localparam logic [2:0] REG_ADDR_LO = 3'd2;
  localparam logic [2:0] REG_ADDR_HI = 3'd3;
  localparam logic [2:0] REG_LEN     = 3'd4;
  localparam logic [2:0] REG_IRQ     = 3'd5;
  localparam logic [2:0] REG_MASK    = 3'd6;

  localparam int B_VALID   = 31;
  localparam int B_ADDR_ON = 30;
  localparam int B_ANUM_HI = 29;
  localparam int B_ANUM_LO = 27;
  localparam int B_RD      = 26;
  localparam int B_WR      = 25;
  localparam int B_CMD2_EN = 8;

  localparam int I_CMD  = 31;
  localparam int I_XFER = 28;
  localparam int I_TMO  = 1;
  localparam int I_OVR  = 0;

  typedef enum logic [1:0] {SEL_CMD1, SEL_CMD2, SEL_ADDR, SEL_BUF} byteSel_e;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD1, S_ADDR, S_WDATA, S_CMD2, S_WAIT_WB, S_WAIT_RB, S_RDATA
  } seqState_e;

  typedef struct packed {
    logic     setCmdDone;
    logic     setXferDone;
    logic     setTimeout;
    byteSel_e sel;
    logic [2:0] addrIdx;
  } seqStrobe_t;

endpackage

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int LEN_W       = 12,
  parameter int TWB_CYC     = 13,
  parameter int TIMEOUT_CYC = 100000
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             startRd,
  input  logic             startWr,
  input  logic             startAddrOn,
  input  logic [2:0]       startAddrNm1,
  input  logic             cmd2En,
  input  logic [LEN_W-1:0] lenM1,
  input  logic             nandRb,
  output logic             busy,
  output seqStrobe_t       strb,
  output logic             nandCle,
  output logic             nandAle,
  output logic             nandWeN,
  output logic             nandReN,
  output logic             nandDoe,
  output logic [LEN_W-1:0] bufIdx,
  output logic             bufWe
);
  localparam int WAIT_MAX = (TIMEOUT_CYC > TWB_CYC) ? TIMEOUT_CYC : TWB_CYC;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
  localparam int SW_W     = $clog2(TWB_CYC + 2) + 1;

  seqState_e        state;
  logic             ph;
  logic [LEN_W-1:0] cnt;
  logic [WAIT_W-1:0] waitCnt;
  logic             rdOp, wrOp, addrOn, cmd2On;
  logic [2:0]       addrNm1;
  logic [LEN_W-1:0] lenQ;
  seqState_e        postAddr, afterCmd1;
  logic             lastRd, lastWr, rbOk, tmoHit, writing;

  always_comb begin
    if (rdOp)      postAddr = cmd2On ? S_CMD2 : S_WAIT_WB;
    else if (wrOp) postAddr = S_WDATA;
    else           postAddr = cmd2On ? S_CMD2 : S_WAIT_WB;
    afterCmd1 = addrOn ? S_ADDR : postAddr;
  end

  assign lastRd = (state == S_RDATA) && ph && (cnt == lenQ);
  assign lastWr = (state == S_WDATA) && ph && (cnt == lenQ);
  assign rbOk   = (state == S_WAIT_RB) && nandRb;
  assign tmoHit = (state == S_WAIT_RB) && !nandRb && (waitCnt == WAIT_W'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; ph <= 1'b0; cnt <= '0; waitCnt <= '0;
      rdOp <= 1'b0; wrOp <= 1'b0; addrOn <= 1'b0; cmd2On <= 1'b0;
      addrNm1 <= '0; lenQ <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state <= S_CMD1; ph <= 1'b0; cnt <= '0;
          rdOp <= startRd; wrOp <= startWr && !startRd; addrOn <= startAddrOn;
          addrNm1 <= startAddrNm1; cmd2On <= cmd2En; lenQ <= lenM1;
        end
        S_CMD1, S_CMD2: begin
          ph <= ~ph;
          if (ph) begin
            state <= (state == S_CMD1) ? afterCmd1 : S_WAIT_WB;
            cnt <= '0; waitCnt <= '0;
          end
        end
        S_ADDR: begin
          ph <= ~ph;
          if (ph) begin
            if (cnt[2:0] == addrNm1) begin state <= postAddr; cnt <= '0; waitCnt <= '0; end
            else cnt <= cnt + 1'b1;
          end
        end
        S_WDATA: begin
          ph <= ~ph;
          if (ph) begin
            if (lastWr) begin state <= cmd2On ? S_CMD2 : S_WAIT_WB; cnt <= '0; waitCnt <= '0; end
            else cnt <= cnt + 1'b1;
          end
        end
        S_WAIT_WB: begin
          if (waitCnt == WAIT_W'(TWB_CYC - 1)) begin state <= S_WAIT_RB; waitCnt <= '0; end
          else waitCnt <= waitCnt + 1'b1;
        end
        S_WAIT_RB: begin
          if (rbOk) begin state <= rdOp ? S_RDATA : S_IDLE; cnt <= '0; ph <= 1'b0; end
          else if (tmoHit) state <= S_IDLE;
          else waitCnt <= waitCnt + 1'b1;
        end
        S_RDATA: begin
          ph <= ~ph;
          if (ph) begin
            if (lastRd) state <= S_IDLE;
            else cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign writing = (state == S_CMD1) || (state == S_CMD2) || (state == S_ADDR) || (state == S_WDATA);
  assign busy    = (state != S_IDLE);
  assign nandCle = (state == S_CMD1) || (state == S_CMD2);
  assign nandAle = (state == S_ADDR);
  assign nandWeN = !(writing && !ph);
  assign nandReN = !((state == S_RDATA) && !ph);
  assign nandDoe = writing;
  assign bufIdx  = cnt;
  assign bufWe   = (state == S_RDATA) && !ph;

  always_comb begin
    strb.setCmdDone  = lastRd || (rbOk && !rdOp);
    strb.setXferDone = lastRd || lastWr;
    strb.setTimeout  = tmoHit;
    strb.addrIdx     = cnt[2:0];
    case (state)
      S_CMD1:  strb.sel = SEL_CMD1;
      S_CMD2:  strb.sel = SEL_CMD2;
      S_ADDR:  strb.sel = SEL_ADDR;
      default: strb.sel = SEL_BUF;
    endcase
  end

  logic [SW_W-1:0] sinceWe;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceWe <= '1;
    else if (!nandWeN) sinceWe <= '0;
    else if (sinceWe != '1) sinceWe <= sinceWe + 1'b1;
  end

  a_r7_guard_before_ready: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT_RB) |-> (sinceWe >= SW_W'(TWB_CYC)));
  a_r2_start_opcode: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (nandCle && !nandWeN));
  a_r6_buf_in_range: assert property (@(posedge clk) disable iff (!rstN)
    bufWe |-> (bufIdx <= lenQ));
  a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rstN)
    strb.setTimeout |=> (!busy && nandWeN && nandReN));
endmodule

// File: rtl/nand_seq_dpath.sv
module nand_seq_dpath
  import nand_seq_pkg::*;
#(
  parameter int LEN_W = 12
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [2:0]       regAddr,
  input  logic [31:0]      regWdata,
  input  logic             busy,
  input  seqStrobe_t       strb,
  input  logic [7:0]       bufRdata,
  output logic             start,
  output logic             cmd2En,
  output logic [LEN_W-1:0] lenM1,
  output logic [7:0]       nandDout,
  output logic [31:0]      irqStatus,
  output logic             irq
);
  logic [7:0]  op1Q, op2Q;
  logic [8:0]  ctl2Q;
  logic [15:0] addrLoQ;
  logic [23:0] addrHiQ;
  logic [31:0] maskQ, setBits, clrBits;
  logic [63:0] addrBytes;
  logic        wrCtl1;

  assign wrCtl1 = regWr && (regAddr == REG_CTL1);
  assign start  = wrCtl1 && !busy && regWdata[B_VALID];
  assign cmd2En = ctl2Q[B_CMD2_EN];

  always_comb begin
    setBits = '0;
    setBits[I_CMD]  = strb.setCmdDone;
    setBits[I_XFER] = strb.setXferDone;
    setBits[I_TMO]  = strb.setTimeout;
    setBits[I_OVR]  = wrCtl1 && busy;
    clrBits = (regWr && (regAddr == REG_IRQ)) ? regWdata : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      op1Q <= '0; op2Q <= '0; ctl2Q <= '0; addrLoQ <= '0; addrHiQ <= '0;
      lenM1 <= '0; maskQ <= '0; irqStatus <= '0;
    end else begin
      if (start) begin
        op1Q <= regWdata[7:0];
        op2Q <= ctl2Q[7:0];
      end
      if (regWr && !busy) begin
        case (regAddr)
          REG_CTL2:    ctl2Q   <= regWdata[8:0];
          REG_ADDR_LO: addrLoQ <= regWdata[15:0];
          REG_ADDR_HI: addrHiQ <= regWdata[23:0];
          REG_LEN:     lenM1   <= regWdata[LEN_W-1:0];
          default: ;
        endcase
      end
      if (regWr && (regAddr == REG_MASK)) maskQ <= regWdata;
      irqStatus <= (irqStatus & ~clrBits) | setBits;
    end
  end

  assign addrBytes = {24'd0, addrHiQ, addrLoQ};
  assign irq = |(irqStatus & maskQ);

  always_comb begin
    case (strb.sel)
      SEL_CMD1: nandDout = op1Q;
      SEL_CMD2: nandDout = op2Q;
      SEL_ADDR: nandDout = addrBytes[{strb.addrIdx, 3'b000} +: 8];
      default:  nandDout = bufRdata;
    endcase
  end

  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtl1 && busy) |=> irqStatus[I_OVR]);
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    strb.setCmdDone |=> irqStatus[I_CMD]);
  a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && (regAddr == REG_IRQ) && regWdata[I_XFER] && !strb.setXferDone) |=> !irqStatus[I_XFER]);
endmodule

// File: rtl/nand_op_seq.sv
module nand_op_seq
  import nand_seq_pkg::*;
#(
  parameter int LEN_W       = 12,
  parameter int TWB_CYC     = 13,
  parameter int TIMEOUT_CYC = 100000
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [2:0]       regAddr,
  input  logic [31:0]      regWdata,
  output logic             irq,
  output logic [31:0]      irqStatus,
  output logic [LEN_W-1:0] bufAddr,
  output logic             bufWe,
  output logic [7:0]       bufWdata,
  input  logic [7:0]       bufRdata,
  output logic             nandCle,
  output logic             nandAle,
  output logic             nandWeN,
  output logic             nandReN,
  output logic [7:0]       nandDout,
  output logic             nandDoe,
  input  logic [7:0]       nandDin,
  input  logic             nandRb
);
  logic             start, busy, cmd2En;
  logic [LEN_W-1:0] lenM1;
  seqStrobe_t       strb;

  assign bufWdata = nandDin;

  nand_seq_ctrl #(.LEN_W(LEN_W), .TWB_CYC(TWB_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .startRd(regWdata[B_RD]), .startWr(regWdata[B_WR]),
    .startAddrOn(regWdata[B_ADDR_ON]), .startAddrNm1(regWdata[B_ANUM_HI:B_ANUM_LO]),
    .cmd2En(cmd2En), .lenM1(lenM1), .nandRb(nandRb), .busy(busy), .strb(strb),
    .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN), .nandReN(nandReN),
    .nandDoe(nandDoe), .bufIdx(bufAddr), .bufWe(bufWe));

  nand_seq_dpath #(.LEN_W(LEN_W)) i_dpath (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .busy(busy), .strb(strb), .bufRdata(bufRdata), .start(start), .cmd2En(cmd2En),
    .lenM1(lenM1), .nandDout(nandDout), .irqStatus(irqStatus), .irq(irq));
endmodule

// File: tb/test_nand_op_seq.sv
module test_nand_op_seq;
  localparam int LEN_W = 12;
  localparam int TWB   = 13;
  localparam int TMO   = 300;

  logic clk = 1'b0, rstN = 1'b0, regWr = 1'b0;
  logic [2:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic irq, bufWe, nandCle, nandAle, nandWeN, nandReN, nandDoe, nandRb;
  logic [31:0] irqStatus;
  logic [LEN_W-1:0] bufAddr;
  logic [7:0] bufWdata, bufRdata, nandDout, nandDin;

  always #4 clk = ~clk;

  nand_op_seq #(.LEN_W(LEN_W), .TWB_CYC(TWB), .TIMEOUT_CYC(TMO)) i_nand_op_seq (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .irq(irq), .irqStatus(irqStatus), .bufAddr(bufAddr), .bufWe(bufWe),
    .bufWdata(bufWdata), .bufRdata(bufRdata), .nandCle(nandCle), .nandAle(nandAle),
    .nandWeN(nandWeN), .nandReN(nandReN), .nandDout(nandDout), .nandDoe(nandDoe),
    .nandDin(nandDin), .nandRb(nandRb));

  // page buffer: source pattern for writes, capture array for reads
  assign bufRdata = 8'h5A + bufAddr[7:0] * 8'd3;
  logic [7:0] capMem [0:255];
  always @(posedge clk) if (bufWe) capMem[bufAddr[7:0]] <= bufWdata;

  // flash model
  int cyc = 0, logN = 0, armCnt = 0, armAck = 0, busyLeft = 0, busyCycles = 0;
  int cmdCnt = 0, cmdAck = 0, rdPtr = 0, reRise = 0, lastWeCyc = 0, gapRef = -1, firstGap = 0;
  logic [7:0] logB [0:255];
  logic [1:0] logK [0:255];   // 0 command, 1 address, 2 data
  always @(posedge clk) begin
    cyc++;
    if (armAck != armCnt) begin armAck = armCnt; busyLeft = busyCycles; end
    else if (busyLeft > 0) busyLeft--;
  end
  assign nandRb = (busyLeft == 0);
  always @(posedge nandWeN) begin
    logB[logN[7:0]] = nandDout;
    logK[logN[7:0]] = nandCle ? 2'd0 : (nandAle ? 2'd1 : 2'd2);
    logN++;
    lastWeCyc = cyc;
    if (nandCle) begin
      cmdCnt++;
      if (nandDout == 8'h10 || nandDout == 8'h30 || nandDout == 8'hD0) armCnt++;
    end
  end
  assign nandDin = 8'hA0 ^ ((cmdAck != cmdCnt) ? 8'd0 : rdPtr[7:0]);
  always @(posedge nandReN) begin
    reRise++;
    if (cmdAck != cmdCnt) begin cmdAck = cmdCnt; rdPtr = 1; end
    else rdPtr++;
  end
  always @(negedge nandReN) if (gapRef != lastWeCyc) begin gapRef = lastWeCyc; firstGap = cyc - lastWeCyc; end

  int nChk = 0, nFail = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin nFail++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask
  task automatic finishRun;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask
  task automatic wrReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWr = 1'b0;
  endtask
  task automatic waitDone;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (irqStatus[31] || irqStatus[1]) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finishRun();
  end

  // vector table: erase, program, large-page read, ID read, reset-style command
  localparam logic [31:0] V_CTL1 [5] = '{32'hD0000060, 32'hE2000080, 32'hE4000000, 32'hC4000090, 32'h800000FF};
  localparam logic [31:0] V_CTL2 [5] = '{32'h1D0, 32'h110, 32'h130, 32'h0, 32'h0};
  localparam logic [31:0] V_LEN  [5] = '{32'd0, 32'd7, 32'd15, 32'd4, 32'd0};
  localparam int          V_CNT  [5] = '{5, 15, 7, 2, 1};
  localparam logic [31:0] V_STAT [5] = '{32'h80000000, 32'h90000000, 32'h90000000, 32'h90000000, 32'h80000000};
  localparam int          V_BUSY [5] = '{20, 30, 25, 0, 0};

  initial begin
    int s;
    repeat (3) @(negedge clk);
    chk(!nandCle && !nandAle && nandWeN && nandReN && !nandDoe, "R1 bus idle",
        {27'd0, nandCle, nandAle, nandWeN, nandReN, nandDoe}, 32'h6);
    chk(irqStatus == 0 && !irq, "R1 status", irqStatus, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    wrReg(3'd2, 32'h1234);
    wrReg(3'd3, 32'hABCDEF);

    s = logN;
    wrReg(3'd0, 32'h00000060);
    repeat (20) @(negedge clk);
    chk(logN == s && nandWeN, "R2 no start without valid", logN - s, 0);

    for (int v = 0; v < 5; v++) begin
      busyCycles = V_BUSY[v];
      wrReg(3'd1, V_CTL2[v]);
      wrReg(3'd4, V_LEN[v]);
      s = logN;
      wrReg(3'd0, V_CTL1[v]);
      waitDone();
      repeat (2) @(negedge clk);
      chk(logN - s == V_CNT[v], "R3/R4/R5 byte count", logN - s, V_CNT[v]);
      chk(logB[s[7:0]] == V_CTL1[v][7:0] && logK[s[7:0]] == 0, "R2 first opcode", logB[s[7:0]], V_CTL1[v][7:0]);
      chk(irqStatus == V_STAT[v], "R8 status", irqStatus, V_STAT[v]);
      if (v == 1) begin
        chk({logB[s+1], logB[s+2], logB[s+3], logB[s+4], logB[s+5]} == 40'h3412EFCDAB && logK[s+1] == 1 && logK[s+5] == 1,
            "R3 address order", {logB[s+2], logB[s+3], logB[s+4], logB[s+5]}, 32'h12EFCDAB);
        for (int k = 0; k < 8; k++)
          chk(logB[s+6+k] == 8'h5A + 8'(3*k) && logK[s+6+k] == 2, "R4 write data", logB[s+6+k], 8'h5A + 8'(3*k));
        chk(logB[s+14] == 8'h10 && logK[s+14] == 0, "R5 confirm after data", logB[s+14], 8'h10);
      end
      if (v == 2) begin
        chk(logB[s+6] == 8'h30 && logK[s+6] == 0, "R5 read confirm before data", logB[s+6], 8'h30);
        for (int k = 0; k < 16; k++)
          chk(capMem[k] == (8'hA0 ^ 8'(k)), "R6 read data", capMem[k], 8'hA0 ^ 8'(k));
      end
      if (v == 3) chk(firstGap >= TWB, "R7 guard interval", firstGap, TWB);
      wrReg(3'd6, 32'h0);
      chk(!irq, "R8 masked off", irq, 0);
      wrReg(3'd6, 32'h80000000);
      chk(irq, "R8 mask on", irq, 1);
      wrReg(3'd5, 32'h10000000);
      chk(irqStatus == (V_STAT[v] & 32'h80000000), "R8 partial clear", irqStatus, V_STAT[v] & 32'h80000000);
      wrReg(3'd5, 32'hFFFFFFFF);
      chk(irqStatus == 0 && !irq, "R8 clear all", irqStatus, 0);
    end

    // clear colliding with set: ID read, len 4
    begin
      int base;
      busyCycles = 0;
      wrReg(3'd1, 32'h0);
      wrReg(3'd4, 32'd4);
      base = reRise;
      wrReg(3'd0, 32'hC4000090);
      wait (reRise == base + 5);
      @(negedge clk); regWr = 1'b1; regAddr = 3'd5; regWdata = 32'h90000000;
      @(negedge clk); regWr = 1'b0;
      chk(irqStatus == 32'h90000000, "R8 set wins over clear", irqStatus, 32'h90000000);
      wrReg(3'd5, 32'h90000000);
      chk(irqStatus == 0, "R8 later clear", irqStatus, 0);
    end

    // start write while busy
    busyCycles = 200;
    wrReg(3'd1, 32'h110);
    wrReg(3'd4, 32'd7);
    s = logN;
    wrReg(3'd0, 32'hE2000080);
    repeat (5) @(negedge clk);
    wrReg(3'd0, 32'h800000FF);
    chk(irqStatus[0], "R9 sticky error", irqStatus, 32'h1);
    waitDone();
    repeat (2) @(negedge clk);
    chk(logN - s == 15 && logB[s[7:0]] == 8'h80, "R9 write ignored", logN - s, 15);
    chk(irqStatus == 32'h90000001, "R9 status", irqStatus, 32'h90000001);
    wrReg(3'd5, 32'hFFFFFFFF);

    // ready stuck low
    busyCycles = 100000;
    wrReg(3'd1, 32'h1D0);
    wrReg(3'd0, 32'hD0000060);
    waitDone();
    @(negedge clk);
    chk(irqStatus == 32'h00000002, "R10 timeout flag", irqStatus, 32'h2);
    chk(nandWeN && nandReN && !nandCle && !nandAle, "R10 bus idle",
        {28'd0, nandWeN, nandReN, nandCle, nandAle}, 32'hC);
    finishRun();
  end
endmodule